// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block walks a circular list of 8-byte transmit descriptors held in host memory. Each descriptor holds a 32-bit control word at its base address and a byte address of a data buffer at base + 4. When a scan request arrives, the engine reads descriptors from its current ring position. It fetches the buffer of each segment one byte at a time and presents the bytes on a streaming output. When the last segment of a packet has been handled, it reports the packet length and raises a completion pulse.

A single 32-bit request port carries every memory access: descriptor reads, buffer reads, and the writes of zero that hand descriptors back to software. Two length encodings are selectable. In byte mode the length field is a byte count. In word mode it is a count of 32-bit words, and an optional small byte count is taken away from it. The two modes also detect the end of the ring differently. A packet found to be incomplete in the middle is dropped, and a drop pulse is raised. One scan pass hands off a bounded number of packets.

Top module: `txring_gather`

## Requirements
- R1: A pass begins only on a `scan_req` cycle in which `ring_start` is nonzero and both `tx_enable` and `chan_active` are high. Otherwise no memory request is issued. The first pass after reset starts at `ring_start`, and later passes resume where the previous one stopped.
- R2: The control word has these fields: bit 31 owned-by-engine, bit 30 first segment, bit 29 last segment, bit 20 subtract enable, bits 25:24 subtract amount, bits 23:22 pad code, and bits 15:0 length field. The buffer address is read from descriptor base + 4.
- R3: With `mode_sel` = 0, the segment length in bytes equals the length field.
- R4: With `mode_sel` = 1, the segment length is the length field times 4. When bit 20 is set, the subtract amount is then taken from it.
- R5: Segment bytes are emitted in rising address order. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its low two bits cleared. A segment of zero length emits nothing, but the engine still steps over it.
- R6: After its buffer has been read, a descriptor whose first-segment bit is clear has its control word written to zero. The head descriptor of a packet is written to zero only after the last segment. `tx_done` and `out_len_valid` pulse on the acknowledge of that final write.
- R7: The reported length is the sum of the segment lengths plus ((pad code − 1) mod 4), where the pad code comes from the last descriptor.
- R8: Ring step in mode 0: add 8, and if the result equals `ring_end`, load `ring_start`. Ring step in mode 1: if the current address equals `ring_end`, load `ring_start`; otherwise add 8.
- R9: If a descriptor met after the start of a packet is not owned, `out_drop` pulses and `tx_done` does not. The head descriptor is left untouched, and the ring position stays on the unowned descriptor.
- R10: A pass ends when a descriptor that would start a packet is not owned, or after 16 packets have completed.
- R11: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_we` and `mem_addr` hold their values. Every write carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_req | input | 1 | Request to start a scan pass |
| ring_start | input | 32 | Byte address of the first descriptor |
| ring_end | input | 32 | Ring end address (meaning depends on mode) |
| tx_enable | input | 1 | Transmit enable for the channel |
| chan_active | input | 1 | Channel activated |
| mode_sel | input | 1 | 0: byte lengths, post-increment wrap; 1: word lengths, pre-check wrap |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Packet data byte |
| out_len_valid | output | 1 | Packet length valid |
| out_len | output | 20 | Packet length including pad adjust |
| tx_done | output | 1 | Packet completed |
| out_drop | output | 1 | Packet abandoned |

## Verification
The assertions assume that memory eventually acknowledges every request and that read data is valid in the acknowledge cycle. They also assume ring addresses are multiples of 8, with `ring_end` reachable from `ring_start` under the selected rule, and that no word-mode subtract exceeds the shifted length. The stimulus keeps descriptors in a region cleared to zero and buffers in a separate region filled with a computed pattern. Memory is modelled as acknowledging every other cycle. Only word-mode descriptors with a length field of at least one ever have the subtract enabled.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int OWN_B   = 31;
  localparam int FIRST_B = 30;
  localparam int LAST_B  = 29;
  localparam int SUBEN_B = 20;
  localparam int SUB_LO  = 24;
  localparam int PAD_LO  = 22;
  localparam int FLEN_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_ADR, ST_BUF, ST_CLR, ST_STEP, ST_HEAD
  } txg_state_e;

  // extra bytes from a pad code: (code - 1) mod 4
  function automatic logic [1:0] pad_extra(input logic [1:0] code);
    return code - 2'd1;
  endfunction
endpackage

// File: rtl/txg_seg_len.sv
module txg_seg_len
  import txg_pkg::*;
#(
  parameter int OUT_W = FLEN_W + 2
) (
  input  logic [31:0]      ctl_word,
  input  logic             mode_sel,
  output logic [OUT_W-1:0] seg_bytes
);
  logic [OUT_W-1:0] raw_len;
  logic [OUT_W-1:0] word_len;
  logic [OUT_W-1:0] sub_len;

  always_comb begin
    raw_len  = OUT_W'(ctl_word[FLEN_W-1:0]);
    word_len = raw_len << 2;
    sub_len  = ctl_word[SUBEN_B] ? OUT_W'(ctl_word[SUB_LO +: 2]) : '0;
    seg_bytes = mode_sel ? (word_len - sub_len) : raw_len;
  end
endmodule

// File: rtl/txg_ring_step.sv
module txg_ring_step #(
  parameter int AW         = 32,
  parameter int STEP_BYTES = 8
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  input  logic          mode_sel,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] inc_addr;

  always_comb begin
    inc_addr = cur_addr + AW'(STEP_BYTES);
    if (!mode_sel) next_addr = (inc_addr == last_addr) ? first_addr : inc_addr;
    else           next_addr = (cur_addr == last_addr) ? first_addr : inc_addr;
  end
endmodule

// File: rtl/txring_gather.sv
module txring_gather
  import txg_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 20,
  parameter int PASS_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_req,
  input  logic [AW-1:0]    ring_start,
  input  logic [AW-1:0]    ring_end,
  input  logic             tx_enable,
  input  logic             chan_active,
  input  logic             mode_sel,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_len_valid,
  output logic [LEN_W-1:0] out_len,
  output logic             tx_done,
  output logic             out_drop
);
  localparam int DESC_BYTES = 8;
  localparam int SEG_W      = FLEN_W + 2;
  localparam int CNT_W      = $clog2(PASS_MAX + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  txg_state_e       state_q, state_d;
  logic [AW-1:0]    ptr_q, ptr_d, head_q, head_d, buf_q, buf_d;
  logic             ptr_ok_q, ptr_ok_d, in_pkt_q, in_pkt_d;
  logic [31:0]      ctl_q, ctl_d;
  logic [SEG_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [SEG_W-1:0] seg_len_w;
  logic [AW-1:0]    ptr_next_w;
  logic             start_ok;

  txg_seg_len #(.OUT_W(SEG_W)) u_len (
    .ctl_word (mem_rdata),
    .mode_sel (mode_sel),
    .seg_bytes(seg_len_w)
  );

  txg_ring_step #(.AW(AW), .STEP_BYTES(DESC_BYTES)) u_step (
    .cur_addr  (ptr_q),
    .first_addr(ring_start),
    .last_addr (ring_end),
    .mode_sel  (mode_sel),
    .next_addr (ptr_next_w)
  );

  assign start_ok = scan_req && (ring_start != '0) && tx_enable && chan_active;

  // next state
  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    ptr_ok_d = ptr_ok_q;
    head_d   = head_q;
    buf_d    = buf_q;
    in_pkt_d = in_pkt_q;
    ctl_d    = ctl_q;
    rem_d    = rem_q;
    total_d  = total_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_IDLE: if (start_ok) begin
        state_d  = ST_CTL;
        cnt_d    = '0;
        in_pkt_d = 1'b0;
        if (!ptr_ok_q) begin
          ptr_d    = ring_start;
          ptr_ok_d = 1'b1;
        end
      end
      ST_CTL: if (mem_ack) begin
        ctl_d = mem_rdata;
        if (!mem_rdata[OWN_B]) begin
          state_d  = ST_IDLE;
          in_pkt_d = 1'b0;
        end else begin
          if (!in_pkt_q) begin
            head_d   = ptr_q;
            total_d  = '0;
            in_pkt_d = 1'b1;
          end
          rem_d   = seg_len_w;
          state_d = ST_ADR;
        end
      end
      ST_ADR: if (mem_ack) begin
        buf_d = mem_rdata[AW-1:0];
        if (rem_q != '0)          state_d = ST_BUF;
        else if (ctl_q[FIRST_B])  state_d = ST_STEP;
        else                      state_d = ST_CLR;
      end
      ST_BUF: if (mem_ack) begin
        buf_d   = buf_q + AW'(1);
        rem_d   = rem_q - SEG_W'(1);
        total_d = total_q + LEN_W'(1);
        if (rem_q == SEG_W'(1)) state_d = ctl_q[FIRST_B] ? ST_STEP : ST_CLR;
      end
      ST_CLR: if (mem_ack) state_d = ST_STEP;
      ST_STEP: begin
        ptr_d   = ptr_next_w;
        state_d = ctl_q[LAST_B] ? ST_HEAD : ST_CTL;
      end
      ST_HEAD: if (mem_ack) begin
        in_pkt_d = 1'b0;
        cnt_d    = cnt_q + CNT_W'(1);
        state_d  = (cnt_q + CNT_W'(1) == CNT_W'(PASS_MAX)) ? ST_IDLE : ST_CTL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      ptr_ok_q <= 1'b0;
      head_q   <= '0;
      buf_q    <= '0;
      in_pkt_q <= 1'b0;
      ctl_q    <= '0;
      rem_q    <= '0;
      total_q  <= '0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      ptr_ok_q <= ptr_ok_d;
      head_q   <= head_d;
      buf_q    <= buf_d;
      in_pkt_q <= in_pkt_d;
      ctl_q    <= ctl_d;
      rem_q    <= rem_d;
      total_q  <= total_d;
      cnt_q    <= cnt_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    case (state_q)
      ST_CTL:  mem_req = 1'b1;
      ST_ADR:  begin mem_req = 1'b1; mem_addr = ptr_q + AW'(4); end
      ST_BUF:  begin mem_req = 1'b1; mem_addr = {buf_q[AW-1:2], 2'b00}; end
      ST_CLR:  begin mem_req = 1'b1; mem_we = 1'b1; end
      ST_HEAD: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head_q; end
      default: ;
    endcase
  end

  // streaming output
  assign out_valid     = (state_q == ST_BUF) && mem_ack;
  assign out_byte      = mem_rdata[8*buf_q[1:0] +: 8];
  assign tx_done       = (state_q == ST_HEAD) && mem_ack;
  assign out_len_valid = tx_done;
  assign out_len       = total_q + LEN_W'(pad_extra(ctl_q[PAD_LO +: 2]));
  assign out_drop      = (state_q == ST_CTL) && mem_ack && in_pkt_q && !mem_rdata[OWN_B];
endmodule

// File: rtl/txring_gather_chk.sv
module txring_gather_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_len_valid,
  input logic          tx_done,
  input logic          out_drop
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == 32'd0));

  // R5
  byte_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mem_req && mem_ack && !mem_we));

  // R6
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || out_len_valid) |-> (mem_req && mem_we && mem_ack));

  // R9
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> (!tx_done && !mem_we && !out_valid));
endmodule

bind txring_gather txring_gather_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .out_valid    (out_valid),
  .out_len_valid(out_len_valid),
  .tx_done      (tx_done),
  .out_drop     (out_drop)
);

// File: tb/txring_gather_test.sv
module txring_gather_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_req = 1'b0;
  logic [31:0] ring_start = 32'h100;
  logic [31:0] ring_end = 32'h200;
  logic        tx_enable = 1'b1;
  logic        chan_active = 1'b1;
  logic        mode_sel = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_len_valid, tx_done, out_drop;
  logic [7:0]  out_byte;
  logic [19:0] out_len;

  always #2.5 clk = ~clk;

  txring_gather uut (
    .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .ring_start(ring_start),
    .ring_end(ring_end), .tx_enable(tx_enable), .chan_active(chan_active),
    .mode_sel(mode_sel), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_byte(out_byte), .out_len_valid(out_len_valid),
    .out_len(out_len), .tx_done(tx_done), .out_drop(out_drop)
  );

  // memory model: 1 KB, acknowledges every other cycle
  logic [31:0] mem [0:255];
  logic        ack_r;
  logic [31:0] rdata_r;
  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;
  always @(posedge clk) begin
    if (!rst_n) ack_r <= 1'b0;
    else if (mem_req && !ack_r) begin
      ack_r   <= 1'b1;
      rdata_r <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end else ack_r <= 1'b0;
  end

  int nchk = 0;
  int errs = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int got_len[$];
  int exp_len[$];
  int done_cnt, drop_cnt, req_cnt;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) got_q.push_back(out_byte);
      if (out_len_valid) got_len.push_back(int'(out_len));
      if (tx_done) done_cnt++;
      if (out_drop) drop_cnt++;
      if (mem_req) req_cnt++;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] ctlw(input bit own, input bit fs, input bit ls,
                                       input bit en, input int sub, input int pad,
                                       input int len);
    logic [31:0] w = 32'd0;
    w[31] = own; w[30] = fs; w[29] = ls; w[20] = en;
    w[25:24] = 2'(sub); w[23:22] = 2'(pad); w[15:0] = 16'(len);
    return w;
  endfunction

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int addr, input logic [31:0] c, input int bufa);
    mem[addr >> 2]       = c;
    mem[(addr >> 2) + 1] = 32'(bufa);
  endtask

  task automatic expect_seg(input int bufa, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(pat(bufa + k));
  endtask

  task automatic clear_obs();
    got_q.delete(); exp_q.delete(); got_len.delete(); exp_len.delete();
    done_cnt = 0; drop_cnt = 0; req_cnt = 0;
  endtask

  task automatic begin_test(input bit m, input int rs, input int re);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = m; ring_start = 32'(rs); ring_end = 32'(re);
    tx_enable = 1'b1; chan_active = 1'b1; scan_req = 1'b0;
    for (int i = 0; i < 256; i++)
      mem[i] = (i >= 64 && i < 128) ? 32'd0 :
               {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_obs();
  endtask

  task automatic run_pass();
    int idle = 0;
    @(negedge clk); scan_req = 1'b1;
    @(negedge clk); scan_req = 1'b0;
    while (idle < 6) begin
      @(negedge clk);
      if (mem_req) idle = 0; else idle++;
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " byte count"}, got_q.size() == exp_q.size(), got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        check({tag, " byte"}, got_q[i] == exp_q[i], got_q[i], exp_q[i]);
    check({tag, " length count"}, got_len.size() == exp_len.size(), got_len.size(), exp_len.size());
    if (got_len.size() == exp_len.size())
      for (int i = 0; i < exp_len.size(); i++)
        check({tag, " length"}, got_len[i] == exp_len[i], got_len[i], exp_len[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; errs++;
    $display("FAIL watchdog expired, all requirements");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    // reset state
    repeat (2) @(negedge clk);
    check("R1 reset mem_req", mem_req == 1'b0, mem_req, 0);
    check("R1 reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R6 reset tx_done", tx_done == 1'b0, tx_done, 0);

    // R1: start gating
    begin_test(1'b0, 32'h100, 32'h200);
    put_desc(32'h100, ctlw(1,1,1,0,0,1,2), 32'h200);
    tx_enable = 1'b0; run_pass();
    check("R1 tx_enable low", req_cnt == 0, req_cnt, 0);
    tx_enable = 1'b1; chan_active = 1'b0; run_pass();
    check("R1 chan_active low", req_cnt == 0, req_cnt, 0);
    chan_active = 1'b1; ring_start = 32'd0; run_pass();
    check("R1 start zero", req_cnt == 0, req_cnt, 0);
    ring_start = 32'h100; run_pass();
    check("R1 enabled pass", done_cnt == 1, done_cnt, 1);

    // R2 R3 R5 R6 R7: byte mode, single and three-segment packets
    begin_test(1'b0, 32'h100, 32'h200);
    put_desc(32'h100, ctlw(1,1,1,0,0,1,5), 32'h201);
    put_desc(32'h108, ctlw(1,1,0,0,0,0,3), 32'h240);
    put_desc(32'h110, ctlw(1,0,0,0,0,0,0), 32'h000);
    put_desc(32'h118, ctlw(1,0,1,0,0,3,4), 32'h263);
    expect_seg(32'h201, 5); exp_len.push_back(5);
    expect_seg(32'h240, 3); expect_seg(32'h263, 4); exp_len.push_back(9);
    run_pass();
    compare("R3 R5 R7 byte mode");
    check("R6 done count", done_cnt == 2, done_cnt, 2);
    for (int d = 0; d < 4; d++)
      check("R6 descriptor cleared", mem[(32'h100 >> 2) + 2*d] == 0, mem[(32'h100 >> 2) + 2*d], 0);

    // R7: pad code sweep
    begin_test(1'b0, 32'h100, 32'h200);
    for (int p = 0; p < 4; p++) begin
      put_desc(32'h100 + 8*p, ctlw(1,1,1,0,0,p,2), 32'h280 + 4*p);
      expect_seg(32'h280 + 4*p, 2);
      exp_len.push_back(2 + ((p + 3) % 4));
    end
    run_pass();
    compare("R7 pad sweep");

    // R4: word mode with subtract sweep, and subtract disabled
    begin_test(1'b1, 32'h100, 32'h1f8);
    for (int s = 0; s < 4; s++) begin
      put_desc(32'h100 + 8*s, ctlw(1,1,1,1,s,1,2), 32'h2c0 + 16*s);
      expect_seg(32'h2c0 + 16*s, 8 - s); exp_len.push_back(8 - s);
    end
    put_desc(32'h120, ctlw(1,1,1,0,3,1,2), 32'h301);
    expect_seg(32'h301, 8); exp_len.push_back(8);
    run_pass();
    compare("R4 word mode");

    // R9: abandon mid packet
    begin_test(1'b0, 32'h100, 32'h200);
    put_desc(32'h100, ctlw(1,1,0,0,0,0,3), 32'h210);
    put_desc(32'h108, ctlw(1,0,0,0,0,0,2), 32'h220);
    run_pass();
    check("R9 drop pulse", drop_cnt == 1, drop_cnt, 1);
    check("R9 no done", done_cnt == 0, done_cnt, 0);
    check("R9 head untouched", mem[32'h100 >> 2] == ctlw(1,1,0,0,0,0,3),
          mem[32'h100 >> 2], ctlw(1,1,0,0,0,0,3));
    check("R6 mid cleared", mem[32'h108 >> 2] == 0, mem[32'h108 >> 2], 0);
    put_desc(32'h110, ctlw(1,0,1,0,0,1,2), 32'h230);
    clear_obs();
    expect_seg(32'h230, 2); exp_len.push_back(2);
    run_pass();
    compare("R9 resume at unowned");

    // R10: 16 packets per pass
    begin_test(1'b0, 32'h100, 32'h1f8);
    for (int i = 0; i < 20; i++) put_desc(32'h100 + 8*i, ctlw(1,1,1,0,0,1,1), 32'h200 + i);
    run_pass();
    check("R10 first pass", done_cnt == 16, done_cnt, 16);
    clear_obs(); run_pass();
    check("R10 second pass", done_cnt == 4, done_cnt, 4);
    clear_obs(); run_pass();
    check("R10 empty pass", done_cnt == 0, done_cnt, 0);

    // R8: ring wrap, both modes (three descriptors)
    for (int m = 0; m < 2; m++) begin
      begin_test(1'(m), 32'h100, (m == 0) ? 32'h118 : 32'h110);
      put_desc(32'h100, ctlw(1,1,1,0,0,1,1), 32'h240);
      put_desc(32'h108, ctlw(1,1,1,0,0,1,1), 32'h241);
      run_pass();
      check("R8 before wrap", done_cnt == 2, done_cnt, 2);
      put_desc(32'h110, ctlw(1,1,1,0,0,1,1), 32'h250);
      put_desc(32'h100, ctlw(1,1,1,0,0,1,1), 32'h260);
      clear_obs();
      expect_seg(32'h250, (m == 0) ? 1 : 4); exp_len.push_back((m == 0) ? 1 : 4);
      expect_seg(32'h260, (m == 0) ? 1 : 4); exp_len.push_back((m == 0) ? 1 : 4);
      run_pass();
      compare("R8 wrap");
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule